// File: doc/BRIEF.md
# Low-Power Subclock Mode Sequencer

This block tracks which low-speed power state a small microcontroller core is in. It runs on the slow watch clock. Watch mode stops everything except timekeeping. Subsleep halts the CPU while peripherals keep running on the subclock. Subactive runs the CPU from a divided subclock. After reset the sequencer reports the high-speed active mode. A sleep strobe, qualified by three control bits, moves it into one of the low-speed states. Enabled, unmasked wake requests bring it back to subactive, or to active.

The wake sources that count depend on the current state. Watch accepts only a narrow group of timers, one external interrupt and the eight wakeup pins. Subsleep accepts every source. The sequencer also generates the CPU clock enable for subactive mode: a one-cycle pulse every 2, 4 or 8 watch-clock cycles. A sleep strobe in subactive that matches neither low-speed target is flagged as a request for a direct transfer to active mode. That request is left to other logic.

Top module: `subclk_mode_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, `mode` is 00 (active), `cpu_ce` is 0 and `direct_req` is 0. Mode encoding: 00 active, 01 subactive, 10 subsleep, 11 watch.
- R2: In subactive or active, `sleep_req` with `standby_sel`=1 and `tmrclk_sel`=1 moves `mode` to watch on the next clock edge, whatever the value of `lowspd_sel`.
- R3: In subactive or active, `sleep_req` with `standby_sel`=0, `lowspd_sel`=1 and `tmrclk_sel`=1 moves `mode` to subsleep on the next clock edge.
- R4: In subactive, `sleep_req` with any other control combination leaves `mode` at subactive and raises `direct_req` for exactly one cycle. In active, such a strobe leaves `mode` at active and `direct_req` at 0.
- R5: Wake source indices: 0 timer A, 1 timer F, 2 timer G, 3 external interrupt 0, 4..11 wakeup pins 0..7, 12 timer C, 13 async event counter, 14 serial interface, 15 event-counter interrupt, 16/17/18 external interrupts 1/3/4. In watch, a counting request on indices 0..11 moves to subactive if `lowspd_sel`=1 and to active if it is 0. Indices 12..18 have no effect in watch.
- R6: In subsleep, a counting request on any of indices 0..18 moves to subactive.
- R7: A request counts only when its `wake_en` bit is 1 and `irq_mask` is 0. Otherwise the state does not change.
- R8: In subactive, a `sleep_req` that arrives together with a counting request (any index) is ignored.
- R9: A request held for several cycles causes only one transition. The state stays in subactive while the request is held.
- R10: `div_sel` 00 gives a `cpu_ce` pulse every 8 cycles, 10 every 4 cycles, and 01 or 11 every 2 cycles.
- R11: `cpu_ce` is high only in subactive. The divider counter is cleared outside subactive, so the first pulse falls in cycle N of subactive, where N is the divide ratio.
- R12: Driving `rst_n` low forces `mode` to active at once, with no clock edge needed, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Watch (sub) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction strobe, one cycle |
| standby_sel | input | 1 | Standby control bit |
| lowspd_sel | input | 1 | Low-speed select control bit |
| tmrclk_sel | input | 1 | Timer clock select control bit |
| irq_mask | input | 1 | Global interrupt mask |
| wake_req | input | NUM_WAKE | Wake request levels, one per source |
| wake_en | input | NUM_WAKE | Per-source wake enable |
| div_sel | input | 2 | Subactive clock divide select |
| mode | output | 2 | Current power mode |
| cpu_ce | output | 1 | Subactive CPU clock enable pulse |
| direct_req | output | 1 | Direct-transfer-to-active request pulse |

## Verification
The bench drives each of the nineteen sources into both watch and subsleep. A design that used a single source set for both states would either wake watch on timer C or the serial interface, or leave subsleep stuck on those sources. It walks all eight control-bit combinations out of subactive and active, which catches an inverted standby priority and a misrouted direct-transfer flag. It times the first enable pulse and the spacing between pulses for every divide code, so a swapped code map or a counter that is not cleared on entry shows up as a wrong cycle index. It also checks a sleep strobe that coincides with a pending wake, a request held for many cycles, and a reset asserted between clock edges.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_SUBACT = 2'b01,
    MODE_SUBSLP = 2'b10,
    MODE_WATCH  = 2'b11
  } lpm_mode_e;

  localparam int LPM_NUM_WAKE = 19;
  localparam logic [LPM_NUM_WAKE-1:0] LPM_WATCH_SET  = 19'h00FFF;
  localparam logic [LPM_NUM_WAKE-1:0] LPM_SUBSLP_SET = 19'h7FFFF;
  localparam int LPM_DIV_W = 3;

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NUM_WAKE = 19,
  parameter logic [NUM_WAKE-1:0] WATCH_SET  = '1,
  parameter logic [NUM_WAKE-1:0] SUBSLP_SET = '1
) (
  input  logic [NUM_WAKE-1:0] wake_req,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                irq_mask,
  output logic                hit_watch,
  output logic                hit_subslp,
  output logic                hit_any
);

  logic [NUM_WAKE-1:0] live;

  // per-source qualification: enabled and not globally masked
  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_src
    assign live[i] = wake_req[i] & wake_en[i] & ~irq_mask;
  end

  assign hit_watch  = |(live & WATCH_SET);
  assign hit_subslp = |(live & SUBSLP_SET);
  assign hit_any    = |live;

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk_w,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      standby_sel,
  input  logic      lowspd_sel,
  input  logic      tmrclk_sel,
  input  logic      hit_watch,
  input  logic      hit_subslp,
  input  logic      hit_any,
  output lpm_mode_e state,
  output logic      direct_req
);

  lpm_mode_e state_nx;
  logic      direct_nx;
  logic      go_watch;
  logic      go_subslp;

  assign go_watch  = standby_sel & tmrclk_sel;
  assign go_subslp = ~standby_sel & lowspd_sel & tmrclk_sel;

  always_comb begin
    state_nx  = state;
    direct_nx = 1'b0;
    unique case (state)
      MODE_ACTIVE: begin
        if (sleep_req) begin
          if (go_watch)       state_nx = MODE_WATCH;
          else if (go_subslp) state_nx = MODE_SUBSLP;
        end
      end
      MODE_SUBACT: begin
        // a pending counted wake outranks the sleep strobe
        if (sleep_req && !hit_any) begin
          if (go_watch)       state_nx = MODE_WATCH;
          else if (go_subslp) state_nx = MODE_SUBSLP;
          else                direct_nx = 1'b1;
        end
      end
      MODE_SUBSLP: begin
        if (hit_subslp) state_nx = MODE_SUBACT;
      end
      MODE_WATCH: begin
        if (hit_watch) state_nx = lowspd_sel ? MODE_SUBACT : MODE_ACTIVE;
      end
      default: state_nx = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_w or negedge rst_n) begin
    if (!rst_n) begin
      state      <= MODE_ACTIVE;
      direct_req <= 1'b0;
    end else begin
      state      <= state_nx;
      direct_req <= direct_nx;
    end
  end

endmodule

// File: rtl/lpm_subclk_div.sv
module lpm_subclk_div #(
  parameter int DIV_W = 3
) (
  input  logic       clk_w,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       cpu_ce
);

  localparam logic [DIV_W-1:0] MASK_FULL = '1;
  localparam logic [DIV_W-1:0] MASK_HALF = MASK_FULL >> 1;
  localparam logic [DIV_W-1:0] MASK_QTR  = MASK_FULL >> 2;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] term;

  // 00 -> slowest, 10 -> middle, x1 -> fastest
  always_comb begin
    if (div_sel[0])      term = MASK_QTR;
    else if (div_sel[1]) term = MASK_HALF;
    else                 term = MASK_FULL;
  end

  always_ff @(posedge clk_w or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign cpu_ce = run && ((cnt & term) == term);

endmodule

// File: rtl/subclk_mode_seq.sv
module subclk_mode_seq
  import lpm_pkg::*;
#(
  parameter int NUM_WAKE = LPM_NUM_WAKE,
  parameter logic [NUM_WAKE-1:0] WATCH_SET  = LPM_WATCH_SET,
  parameter logic [NUM_WAKE-1:0] SUBSLP_SET = LPM_SUBSLP_SET,
  parameter int DIV_W = LPM_DIV_W
) (
  input  logic                clk_w,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic                standby_sel,
  input  logic                lowspd_sel,
  input  logic                tmrclk_sel,
  input  logic                irq_mask,
  input  logic [NUM_WAKE-1:0] wake_req,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic [1:0]          div_sel,
  output logic [1:0]          mode,
  output logic                cpu_ce,
  output logic                direct_req
);

  logic      hit_watch;
  logic      hit_subslp;
  logic      hit_any;
  lpm_mode_e state;

  lpm_wake_qual #(
    .NUM_WAKE  (NUM_WAKE),
    .WATCH_SET (WATCH_SET),
    .SUBSLP_SET(SUBSLP_SET)
  ) u_qual (
    .wake_req  (wake_req),
    .wake_en   (wake_en),
    .irq_mask  (irq_mask),
    .hit_watch (hit_watch),
    .hit_subslp(hit_subslp),
    .hit_any   (hit_any)
  );

  lpm_mode_fsm u_fsm (
    .clk_w      (clk_w),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .standby_sel(standby_sel),
    .lowspd_sel (lowspd_sel),
    .tmrclk_sel (tmrclk_sel),
    .hit_watch  (hit_watch),
    .hit_subslp (hit_subslp),
    .hit_any    (hit_any),
    .state      (state),
    .direct_req (direct_req)
  );

  lpm_subclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_w  (clk_w),
    .rst_n  (rst_n),
    .run    (state == MODE_SUBACT),
    .div_sel(div_sel),
    .cpu_ce (cpu_ce)
  );

  assign mode = state;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
  import lpm_pkg::*;
#(
  parameter int NUM_WAKE = LPM_NUM_WAKE
) (
  input logic                clk_w,
  input logic                rst_n,
  input logic                sleep_req,
  input logic                standby_sel,
  input logic                lowspd_sel,
  input logic                tmrclk_sel,
  input logic                irq_mask,
  input logic [NUM_WAKE-1:0] wake_req,
  input logic [NUM_WAKE-1:0] wake_en,
  input logic [1:0]          div_sel,
  input logic [1:0]          mode,
  input logic                cpu_ce,
  input logic                direct_req
);

  logic none_pending;
  assign none_pending = ((wake_req & wake_en) == '0);

  p_reset_active_r1: assert property (@(posedge clk_w) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == MODE_ACTIVE && !cpu_ce && !direct_req));

  p_sleep_watch_r2: assert property (@(posedge clk_w) disable iff (!rst_n)
    (mode == MODE_SUBACT && sleep_req && standby_sel && tmrclk_sel && none_pending)
    |=> mode == MODE_WATCH);

  p_sleep_subslp_r3: assert property (@(posedge clk_w) disable iff (!rst_n)
    (mode == MODE_SUBACT && sleep_req && !standby_sel && lowspd_sel && tmrclk_sel
     && none_pending) |=> mode == MODE_SUBSLP);

  p_direct_in_subact_r4: assert property (@(posedge clk_w) disable iff (!rst_n)
    direct_req |-> mode == MODE_SUBACT);

  p_subslp_exit_r6: assert property (@(posedge clk_w) disable iff (!rst_n)
    (mode == MODE_SUBSLP) |=> (mode == MODE_SUBSLP || mode == MODE_SUBACT));

  p_watch_masked_r7: assert property (@(posedge clk_w) disable iff (!rst_n)
    (mode == MODE_WATCH && irq_mask) |=> mode == MODE_WATCH);

  p_div8_gap_r10: assert property (@(posedge clk_w) disable iff (!rst_n)
    (cpu_ce && div_sel == 2'b00 && $stable(div_sel)) |=> !cpu_ce);

  p_ce_only_subact_r11: assert property (@(posedge clk_w) disable iff (!rst_n)
    cpu_ce |-> mode == MODE_SUBACT);

endmodule

bind subclk_mode_seq lpm_seq_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (
  .clk_w      (clk_w),
  .rst_n      (rst_n),
  .sleep_req  (sleep_req),
  .standby_sel(standby_sel),
  .lowspd_sel (lowspd_sel),
  .tmrclk_sel (tmrclk_sel),
  .irq_mask   (irq_mask),
  .wake_req   (wake_req),
  .wake_en    (wake_en),
  .div_sel    (div_sel),
  .mode       (mode),
  .cpu_ce     (cpu_ce),
  .direct_req (direct_req)
);

// File: tb/subclk_mode_seq_tb_top.sv
`timescale 1ns/1ps
module subclk_mode_seq_tb_top;

  localparam int NW = 19;
  localparam logic [1:0] M_ACT = 2'b00;
  localparam logic [1:0] M_SA  = 2'b01;
  localparam logic [1:0] M_SS  = 2'b10;
  localparam logic [1:0] M_WT  = 2'b11;

  logic          clk_w = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 1'b0;
  logic          standby_sel = 1'b0;
  logic          lowspd_sel = 1'b0;
  logic          tmrclk_sel = 1'b0;
  logic          irq_mask = 1'b0;
  logic [NW-1:0] wake_req = '0;
  logic [NW-1:0] wake_en = '0;
  logic [1:0]    div_sel = 2'b00;
  logic [1:0]    mode;
  logic          cpu_ce;
  logic          direct_req;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk_w = ~clk_w;

  subclk_mode_seq dut_i (
    .clk_w      (clk_w),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .standby_sel(standby_sel),
    .lowspd_sel (lowspd_sel),
    .tmrclk_sel (tmrclk_sel),
    .irq_mask   (irq_mask),
    .wake_req   (wake_req),
    .wake_en    (wake_en),
    .div_sel    (div_sel),
    .mode       (mode),
    .cpu_ce     (cpu_ce),
    .direct_req (direct_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_w) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      finish_run();
    end
  end

  // one clock of stimulus, inputs cleared afterwards, sampled at the next negedge
  task automatic drive(input logic slp, input logic [2:0] ctl, input logic msk,
                       input logic [NW-1:0] req, input logic [NW-1:0] en);
    @(negedge clk_w);
    sleep_req = slp;
    {standby_sel, lowspd_sel, tmrclk_sel} = ctl;
    irq_mask = msk;
    wake_req = req;
    wake_en  = en;
    @(negedge clk_w);
    sleep_req = 1'b0;
    wake_req  = '0;
    irq_mask  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_w);
    rst_n = 1'b0;
    sleep_req = 1'b0;
    wake_req = '0;
    wake_en = '0;
    irq_mask = 1'b0;
    @(negedge clk_w);
    rst_n = 1'b1;
    @(negedge clk_w);
  endtask

  task automatic go_watch();
    do_reset();
    drive(1'b1, 3'b101, 1'b0, '0, '0);
  endtask

  task automatic go_subslp();
    do_reset();
    drive(1'b1, 3'b011, 1'b0, '0, '0);
  endtask

  task automatic go_subact();
    go_subslp();
    drive(1'b0, 3'b000, 1'b0, 19'h00001, 19'h00001);
  endtask

  task automatic t_reset();
    @(negedge clk_w);
    check("R1 mode in reset", mode, M_ACT);
    check("R1 cpu_ce in reset", cpu_ce, 0);
    rst_n = 1'b1;
    @(negedge clk_w);
    check("R1 mode after reset", mode, M_ACT);
    check("R1 direct_req after reset", direct_req, 0);
  endtask

  task automatic t_sleep_combos();
    for (int c = 0; c < 8; c++) begin
      logic [2:0] ctl;
      logic [1:0] exp_sa;
      logic [1:0] exp_act;
      ctl = 3'(c);
      if (ctl[2] && ctl[0])        begin exp_sa = M_WT; exp_act = M_WT; end
      else if (ctl == 3'b011)      begin exp_sa = M_SS; exp_act = M_SS; end
      else                         begin exp_sa = M_SA; exp_act = M_ACT; end
      go_subact();
      drive(1'b1, ctl, 1'b0, '0, '0);
      check($sformatf("R2/R3 subact sleep ctl=%0d", c), mode, exp_sa);
      check($sformatf("R4 direct_req ctl=%0d", c), direct_req, exp_sa == M_SA);
      @(negedge clk_w);
      check($sformatf("R4 direct_req one cycle ctl=%0d", c), direct_req, 0);
      do_reset();
      drive(1'b1, ctl, 1'b0, '0, '0);
      check($sformatf("R2/R3 active sleep ctl=%0d", c), mode, exp_act);
      check($sformatf("R4 no direct_req in active ctl=%0d", c), direct_req, 0);
    end
  endtask

  task automatic t_watch_wake();
    for (int s = 0; s < NW; s++) begin
      for (int ls = 0; ls < 2; ls++) begin
        logic [1:0] exp;
        exp = (s < 12) ? (ls != 0 ? M_SA : M_ACT) : M_WT;
        go_watch();
        drive(1'b0, {1'b0, 1'(ls), 1'b0}, 1'b0, NW'(1) << s, NW'(1) << s);
        check($sformatf("R5 watch wake src=%0d ls=%0d", s, ls), mode, exp);
      end
    end
  endtask

  task automatic t_subslp_wake();
    for (int s = 0; s < NW; s++) begin
      go_subslp();
      drive(1'b0, 3'b000, 1'b0, NW'(1) << s, NW'(1) << s);
      check($sformatf("R6 subsleep wake src=%0d", s), mode, M_SA);
    end
  endtask

  task automatic t_mask();
    go_watch();
    drive(1'b0, 3'b010, 1'b1, 19'h00001, 19'h00001);
    check("R7 watch masked", mode, M_WT);
    drive(1'b0, 3'b010, 1'b0, 19'h00010, 19'h7FFEF);
    check("R7 watch source disabled", mode, M_WT);
    go_subslp();
    drive(1'b0, 3'b000, 1'b1, 19'h40000, 19'h40000);
    check("R7 subsleep masked", mode, M_SS);
    drive(1'b0, 3'b000, 1'b0, 19'h40000, 19'h3FFFF);
    check("R7 subsleep source disabled", mode, M_SS);
    check("R11 no cpu_ce in subsleep", cpu_ce, 0);
  endtask

  task automatic t_wake_wins();
    go_subact();
    drive(1'b1, 3'b101, 1'b0, 19'h01000, 19'h01000);
    check("R8 sleep ignored with pending wake", mode, M_SA);
    check("R8 no direct_req with pending wake", direct_req, 0);
    drive(1'b1, 3'b101, 1'b1, 19'h01000, 19'h01000);
    check("R8 masked wake does not block sleep", mode, M_WT);
  endtask

  task automatic t_held();
    int bad;
    go_subslp();
    @(negedge clk_w);
    wake_req = 19'h00800;
    wake_en  = 19'h00800;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_w);
      if (mode != M_SA) bad++;
    end
    check("R9 held wake stays subactive", bad, 0);
    wake_req = '0;
    @(negedge clk_w);
    check("R9 after release", mode, M_SA);
  endtask

  task automatic t_div();
    for (int c = 0; c < 4; c++) begin
      int ratio;
      int first;
      int last;
      int bad_gap;
      ratio = (c == 0) ? 8 : (c == 2) ? 4 : 2;
      div_sel = 2'(c);
      go_subact();
      first = 0;
      last = 0;
      bad_gap = 0;
      for (int i = 1; i <= 40; i++) begin
        if (cpu_ce) begin
          if (first == 0) first = i;
          else if (i - last != ratio) bad_gap++;
          last = i;
        end
        @(negedge clk_w);
      end
      check($sformatf("R11 first pulse cycle sel=%0d", c), first, ratio);
      check($sformatf("R10 pulse spacing sel=%0d", c), bad_gap, 0);
    end
    div_sel = 2'b00;
  endtask

  task automatic t_async_reset();
    go_watch();
    check("R12 in watch before reset", mode, M_WT);
    #2;
    rst_n = 1'b0;
    #1;
    check("R12 async reset from watch", mode, M_ACT);
    @(negedge clk_w);
    rst_n = 1'b1;
    go_subact();
    #2;
    rst_n = 1'b0;
    #1;
    check("R12 async reset from subactive", mode, M_ACT);
    check("R12 cpu_ce cleared", cpu_ce, 0);
    @(negedge clk_w);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_sleep_combos();
    t_watch_wake();
    t_subslp_wake();
    t_mask();
    t_wake_wins();
    t_held();
    t_div();
    t_async_reset();
    @(negedge clk_w);
    finish_run();
  end

endmodule